// File: doc/BRIEF.md
# Serial Result Output Port

This block moves a 16-bit conversion result off chip one bit at a time, most significant bit first. It has four timing modes, chosen by a 2-bit mode input. In the two generated-clock modes the port makes its own serial clock from the master clock and wraps each word in an active-low frame strobe. In the two host-clocked modes an external host supplies the serial clock, and the port presents a new bit after each falling edge of that clock.

A result enters through a pending register whenever `result_vld` pulses. The word being shifted sits in a separate shift register, so a result that arrives mid-word does not disturb the transfer in progress. In free-running mode each new result starts a frame at once. In self-clocked mode a falling `hold_n` sends the stored result. In pipelined mode a falling `hold_n` loads the previous result for the host to read while the next conversion runs. In burst mode the end of conversion, seen as a falling `conv_busy`, loads the fresh result for a burst read. The external clock passes through a synchroniser before its edges are detected.

Top module: `serial_result_port`

## Requirements
- R1: After reset, `sdata` is 0, `sclk_out` is 0 and `frame_n` is 1.
- R2: `sclk_oe` is 1 for mode codes 0 (free-running) and 1 (self-clocked), and 0 for codes 2 (pipelined) and 3 (burst). In codes 2 and 3, `sclk_out` stays 0 and `frame_n` stays 1.
- R3: In free-running mode, a `result_vld` pulse starts a frame carrying that result. Within the frame, `sdata` sampled at the 16 rising `sclk_out` edges gives the word, MSB first.
- R4: The generated clock is low for HALF_CYC master cycles and then high for HALF_CYC master cycles (default 2), so successive rises are 2*HALF_CYC cycles apart. `sdata` changes only while `sclk_out` is low. `sclk_out` rises only while `frame_n` is low. `frame_n` returns high in the same cycle that `sclk_out` falls after the last high phase.
- R5: In self-clocked mode, a falling `hold_n` starts a frame carrying the result stored before that cycle.
- R6: A `result_vld` that arrives during a frame does not alter the word being sent. It is stored and sent by the next trigger.
- R7: In pipelined mode, a falling `hold_n` loads the previously stored result. A `result_vld` in the same cycle is not used. The MSB is on `sdata` one cycle after the fall.
- R8: In the host-clocked modes, each falling `sclk_in` presents the next bit on `sdata` at the third master clock edge after the fall. Rising `sclk_in` edges do not change `sdata`.
- R9: In burst mode, a falling `conv_busy` loads the result (the `result` input if `result_vld` is high in that cycle, otherwise the stored word). If `sclk_in` is low, the MSB is on `sdata` one cycle later.
- R10: In burst mode, if `sclk_in` is high when `conv_busy` falls, `sdata` keeps its previous value until the next falling `sclk_in`, which presents the MSB.
- R11: After the LSB has been presented, `sdata` holds it until a new word is loaded. Further falling `sclk_in` edges have no effect.
- R12: In free-running mode, a `result_vld` that arrives during a frame does not start another frame after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 0 free-running, 1 self-clocked, 2 pipelined, 3 burst |
| result | input | 16 | Conversion result word |
| result_vld | input | 1 | One-cycle strobe marking `result` valid |
| hold_n | input | 1 | Sample command, active low; its falling edge is the trigger |
| conv_busy | input | 1 | High while converting; a fall marks conversion done |
| sclk_in | input | 1 | Host serial clock (pipelined and burst modes) |
| sdata | output | 1 | Serial data, MSB first |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | High when the port drives the serial clock |
| frame_n | output | 1 | Frame strobe, active low, generated-clock modes |

## Verification
Any corruption of the shift register, bit counter or phase counter is visible at the ports within one serial word. A wrong bit count gives the wrong number of rises inside a frame. A bad phase counter shifts the spacing between rises. A bad shift register sends the wrong word or loses the held LSB. Faults in the load and trigger logic appear within one master cycle of the trigger as a missing or stale MSB, or as a frame starting when none should. Synchroniser faults show up as a change in the fixed three-edge latency from a falling host clock to new data.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [1:0] {
        SM_FREE  = 2'd0,
        SM_SELF  = 2'd1,
        SM_PIPE  = 2'd2,
        SM_BURST = 2'd3
    } srp_mode_e;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_LOW  = 2'd1,
        GS_HIGH = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic level;
        logic fall;
    } sync_edge_t;

    function automatic logic mode_drives_clock(srp_mode_e m);
        return (m == SM_FREE) || (m == SM_SELF);
    endfunction

endpackage

// File: rtl/srp_sclk_sync.sv
module srp_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                din,
    output srp_pkg::sync_edge_t edge_o
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], din};
    end

    always_comb begin
        edge_o.level = pipe[STAGES-1];
        edge_o.fall  = pipe[STAGES] & ~pipe[STAGES-1];
    end
endmodule

// File: rtl/srp_word_buf.sv
module srp_word_buf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] wr_data,
    input  logic         wr_en,
    output logic [W-1:0] stored,
    output logic [W-1:0] fresh
);
    always_ff @(posedge clk) begin
        if (rst)        stored <= '0;
        else if (wr_en) stored <= wr_data;
    end

    assign fresh = wr_en ? wr_data : stored;
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import srp_pkg::*;
#(
    parameter int W           = 16,
    parameter int HALF_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic [W-1:0] result,
    input  logic         result_vld,
    input  logic         hold_n,
    input  logic         conv_busy,
    input  logic         sclk_in,
    output logic         sdata,
    output logic         sclk_out,
    output logic         sclk_oe,
    output logic         frame_n
);
    localparam int CNT_W = $clog2(W + 1);
    localparam int PH_W  = $clog2(HALF_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_BITS = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS  = CNT_W'(W);
    localparam logic [PH_W-1:0]  PH_END    = PH_W'(HALF_CYC - 1);

    srp_mode_e  md;
    sync_edge_t ext;
    logic [W-1:0] stored_w, fresh_w, load_w;
    logic [W-1:0] shreg;
    logic [CNT_W-1:0] remain;
    logic [PH_W-1:0]  ph;
    gen_state_e st;
    logic sd_q, sclk_q, frame_q;
    logic hold_q, busy_q;
    logic hold_fall, done_fall, gen_start, ext_load, defer;

    assign md = srp_mode_e'(mode);

    srp_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(sclk_in), .edge_o(ext)
    );

    srp_word_buf #(.W(W)) u_buf (
        .clk(clk), .rst(rst), .wr_data(result), .wr_en(result_vld),
        .stored(stored_w), .fresh(fresh_w)
    );

    assign hold_fall = hold_q & ~hold_n;
    assign done_fall = busy_q & ~conv_busy;

    always_comb begin
        unique case (md)
            SM_FREE:  load_w = result;
            SM_BURST: load_w = fresh_w;
            default:  load_w = stored_w;
        endcase
    end

    assign gen_start = (st == GS_IDLE) &&
                       (((md == SM_FREE) && result_vld) || ((md == SM_SELF) && hold_fall));
    assign ext_load  = ((md == SM_PIPE) && hold_fall) || ((md == SM_BURST) && done_fall);
    assign defer     = (md == SM_BURST) && ext.level;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            remain  <= '0;
            ph      <= '0;
            st      <= GS_IDLE;
            sd_q    <= 1'b0;
            sclk_q  <= 1'b0;
            frame_q <= 1'b1;
            hold_q  <= 1'b1;
            busy_q  <= 1'b0;
        end else begin
            hold_q <= hold_n;
            busy_q <= conv_busy;
            if (mode_drives_clock(md)) begin
                unique case (st)
                    GS_IDLE: begin
                        if (gen_start) begin
                            sd_q    <= load_w[W-1];
                            shreg   <= {load_w[W-2:0], 1'b0};
                            remain  <= LAST_BITS;
                            frame_q <= 1'b0;
                            sclk_q  <= 1'b0;
                            ph      <= '0;
                            st      <= GS_LOW;
                        end
                    end
                    GS_LOW: begin
                        if (ph == PH_END) begin
                            sclk_q <= 1'b1;
                            ph     <= '0;
                            st     <= GS_HIGH;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    GS_HIGH: begin
                        if (ph == PH_END) begin
                            sclk_q <= 1'b0;
                            ph     <= '0;
                            if (remain == '0) begin
                                frame_q <= 1'b1;
                                st      <= GS_IDLE;
                            end else begin
                                sd_q   <= shreg[W-1];
                                shreg  <= {shreg[W-2:0], 1'b0};
                                remain <= remain - 1'b1;
                                st     <= GS_LOW;
                            end
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    default: st <= GS_IDLE;
                endcase
            end else begin
                st      <= GS_IDLE;
                frame_q <= 1'b1;
                sclk_q  <= 1'b0;
                ph      <= '0;
                if (ext_load) begin
                    if (defer) begin
                        shreg  <= load_w;
                        remain <= ALL_BITS;
                    end else begin
                        sd_q   <= load_w[W-1];
                        shreg  <= {load_w[W-2:0], 1'b0};
                        remain <= LAST_BITS;
                    end
                end else if (ext.fall && (remain != '0)) begin
                    sd_q   <= shreg[W-1];
                    shreg  <= {shreg[W-2:0], 1'b0};
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    assign sdata    = sd_q;
    assign sclk_out = sclk_q;
    assign frame_n  = frame_q;
    assign sclk_oe  = mode_drives_clock(md);
endmodule

// File: rtl/srp_checker.sv
module srp_checker (
    input logic clk,
    input logic rst,
    input logic sdata,
    input logic sclk_out,
    input logic sclk_oe,
    input logic frame_n
);
    a_r2_quiet_when_hosted: assert property (@(posedge clk) disable iff (rst)
        !sclk_oe |-> (frame_n && !sclk_out));

    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (rst)
        sclk_out |-> $stable(sdata));

    a_r4_high_phase_width: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_out) |=> sclk_out);

    a_r4_low_phase_width: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk_out) && !frame_n) |=> !sclk_out);

    a_r4_rise_inside_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_out) |-> !frame_n);

    a_r4_frame_ends_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_n) |-> $fell(sclk_out));
endmodule

bind serial_result_port srp_checker u_srp_checker (
    .clk(clk), .rst(rst), .sdata(sdata), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .frame_n(frame_n)
);

// File: tb/tb_serial_result_port.sv
module tb_serial_result_port;
    localparam int HALF = 2;
    localparam int NV   = 6;
    localparam logic [15:0] VEC [NV] = '{16'hA5C3, 16'h0001, 16'h8000,
                                         16'hFFFF, 16'h0000, 16'h1234};
    localparam logic [15:0] WA = 16'h3C5A, WB = 16'hC0DE, WC = 16'h7777,
                            WD = 16'h9AB1, WE = 16'h4F00;

    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic [15:0] result = '0;
    logic result_vld = 1'b0, hold_n = 1'b1, conv_busy = 1'b0, sclk_in = 1'b0;
    logic sdata, sclk_out, sclk_oe, frame_n;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_result_port dut (
        .clk(clk), .rst(rst), .mode(mode), .result(result), .result_vld(result_vld),
        .hold_n(hold_n), .conv_busy(conv_busy), .sclk_in(sclk_in),
        .sdata(sdata), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .frame_n(frame_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_sclk(input logic v);
        @(negedge clk) sclk_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic cap_gen(output logic [15:0] w, output int rises, output int bad_per);
        int cyc = 0, last = -1, guard = 0;
        logic prev;
        w = '0; rises = 0; bad_per = 0;
        while (frame_n && guard < 200) begin @(negedge clk); guard++; end
        prev = sclk_out;
        while (!frame_n && guard < 1000) begin
            @(negedge clk); cyc++; guard++;
            if (sclk_out && !prev) begin
                w = {w[14:0], sdata};
                rises++;
                if (last >= 0 && cyc - last != 2 * HALF) bad_per++;
                last = cyc;
            end
            prev = sclk_out;
        end
    endtask

    task automatic rd_ext(output logic [15:0] w);
        logic b;
        w = '0;
        for (int i = 0; i < 16; i++) begin
            b = sdata;
            w = {w[14:0], b};
            set_sclk(1'b1);
            if (i == 3) check(sdata == b, "R8 rising sclk_in no effect", sdata, b);
            set_sclk(1'b0);
        end
    endtask

    initial begin
        logic [15:0] w;
        int rises, bad, extra;
        repeat (3) @(negedge clk);
        check(sdata == 1'b0 && sclk_out == 1'b0 && frame_n == 1'b1, "R1 reset state",
              {sdata, sclk_out, frame_n}, 3'b001);
        @(negedge clk) rst = 1'b0;

        // R2 direction per mode
        mode = 2'd2; @(negedge clk);
        check(sclk_oe == 1'b0 && frame_n && !sclk_out, "R2 pipelined no clock drive", sclk_oe, 0);
        mode = 2'd3; @(negedge clk);
        check(sclk_oe == 1'b0, "R2 burst no clock drive", sclk_oe, 0);
        mode = 2'd1; @(negedge clk);
        check(sclk_oe == 1'b1, "R2 self-clocked drives clock", sclk_oe, 1);
        mode = 2'd0; @(negedge clk);
        check(sclk_oe == 1'b1, "R2 free-running drives clock", sclk_oe, 1);

        // R3 R4 R11 table of words in free-running mode
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) begin result = VEC[i]; result_vld = 1'b1; end
            @(negedge clk) result_vld = 1'b0;
            cap_gen(w, rises, bad);
            check(w == VEC[i], "R3 free-running word", w, VEC[i]);
            check(rises == 16, "R3 rise count", rises, 16);
            check(bad == 0, "R4 rise spacing", bad, 0);
            check(sdata == VEC[i][0], "R11 LSB held after frame", sdata, VEC[i][0]);
            repeat (3) @(negedge clk);
        end

        // R6 R12: new result mid-frame
        @(negedge clk) begin result = WA; result_vld = 1'b1; end
        @(negedge clk) result_vld = 1'b0;
        fork
            cap_gen(w, rises, bad);
            begin
                repeat (20) @(negedge clk);
                result = WB; result_vld = 1'b1;
                @(negedge clk) result_vld = 1'b0;
            end
        join
        check(w == WA, "R6 word unaffected by mid-frame result", w, WA);
        extra = 0;
        for (int i = 0; i < 80; i++) begin @(negedge clk); if (!frame_n) extra++; end
        check(extra == 0, "R12 no frame from mid-frame result", extra, 0);

        // R5 self-clocked sends stored word
        mode = 2'd1;
        @(negedge clk) hold_n = 1'b0;
        @(negedge clk) hold_n = 1'b1;
        cap_gen(w, rises, bad);
        check(w == WB, "R5 self-clocked stored word", w, WB);
        check(w == WB, "R6 stored word sent by next trigger", w, WB);
        repeat (3) @(negedge clk);

        // R7 pipelined: previous result loaded
        mode = 2'd2;
        @(negedge clk) begin hold_n = 1'b0; result = WC; result_vld = 1'b1; end
        @(negedge clk) begin hold_n = 1'b1; result_vld = 1'b0; end
        check(sdata == WB[15], "R7 MSB one cycle after hold fall", sdata, WB[15]);
        rd_ext(w);
        check(w == WB, "R7 pipelined previous word", w, WB);
        check(sdata == WB[0], "R11 LSB held after extra fall", sdata, WB[0]);

        // R9 burst: fresh result at done
        mode = 2'd3;
        @(negedge clk) conv_busy = 1'b1;
        repeat (3) @(negedge clk);
        conv_busy = 1'b0; result = WD; result_vld = 1'b1;
        @(negedge clk) result_vld = 1'b0;
        check(sdata == WD[15], "R9 burst MSB after done", sdata, WD[15]);
        rd_ext(w);
        check(w == WD, "R9 burst word", w, WD);

        // R10 burst with sclk_in high at done
        set_sclk(1'b1);
        @(negedge clk) conv_busy = 1'b1;
        repeat (3) @(negedge clk);
        conv_busy = 1'b0; result = WE; result_vld = 1'b1;
        @(negedge clk) result_vld = 1'b0;
        repeat (3) @(negedge clk);
        check(sdata == WD[0], "R10 old bit kept while sclk_in high", sdata, WD[0]);
        set_sclk(1'b0);
        check(sdata == WE[15], "R10 MSB after next fall", sdata, WE[15]);
        rd_ext(w);
        check(w == WE, "R10 deferred burst word", w, WE);

        // R8 exact latency, pipelined reload of stored word (WE)
        mode = 2'd2;
        @(negedge clk) hold_n = 1'b0;
        @(negedge clk) hold_n = 1'b1;
        check(sdata == WE[15], "R7 MSB after hold fall", sdata, WE[15]);
        set_sclk(1'b1);
        @(negedge clk) sclk_in = 1'b0;
        repeat (2) @(negedge clk);
        check(sdata == WE[15], "R8 no change before third edge", sdata, WE[15]);
        @(negedge clk);
        check(sdata == WE[14], "R8 next bit at third edge", sdata, WE[14]);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule